// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive path of an Ethernet MAC and decides whether a frame is kept. It watches the incoming byte stream, gathers the six destination address bytes and runs a CRC-32 over them as they arrive. In the cycle after the sixth byte it issues one registered verdict: accept or reject. With the verdict come two flags that classify the address as broadcast or multicast.

The verdict depends on the configured station address, on three enable bits and on a 64-bit multicast hash table. Promiscuous mode accepts everything. An all-ones address is accepted only when broadcast reception is on. The flow-control pause group address is always kept. Other group addresses go through the hash table, and only if multicast reception is on. An individual address must match the station address exactly. A frame that ends before its address is complete produces no verdict.

Top module: `rx_da_filter`

## Requirements
- R1: While `rst_n` is low and after its release, `dec_vld`, `dec_accept`, `dec_bcast` and `dec_mcast` are 0 until a complete address has been taken.
- R2: A byte is taken when `rx_vld` is high and either `rx_sof` is high (this byte becomes address byte 0) or a frame is open. Cycles with `rx_vld` low are skipped. `dec_vld` is high for exactly one cycle, the cycle after the edge that takes address byte 5.
- R3: `dec_accept`, `dec_bcast` and `dec_mcast` are 0 whenever `dec_vld` is 0. Bytes that arrive after the verdict and before the next `rx_sof` produce no further verdict.
- R4: If `rx_eof` is high in a cycle that does not take address byte 5, the open frame is dropped with no verdict, and bytes without `rx_sof` that follow are ignored. `rx_eof` in the same cycle as byte 5 still yields the verdict.
- R5: With `cfg_promisc` high, every verdict is accept.
- R6: The all-ones address sets `dec_bcast`. It is accepted only if `cfg_bcast_en` is high (or R5 applies).
- R7: `sta_addr[47:40]` is address byte 0 and `sta_addr[7:0]` is byte 5. This is three 16-bit words, word 0 in bits 47:32, with the high byte of each word first on the wire. An address with bit 0 of byte 0 clear is accepted only when all 48 bits equal `sta_addr`.
- R8: `dec_mcast` is set when bit 0 of byte 0 is 1 and the address is not all ones. `dec_bcast` and `dec_mcast` are never both 1.
- R9: For a multicast address other than the pause address, the CRC register starts at 0xFFFFFFFF. For each byte, from byte 0, and each bit from bit 0 to bit 7, the register shifts left by one. It is then XORed with 0x04C11DB7 when the old bit 31 differed from the data bit. The key is bits 30:25 of the final value. Key bits 5:3 pick the 8-bit slice `hash_tbl[8t+7:8t]` and key bits 2:0 pick the bit within it, so the selected bit is `hash_tbl[key]`. The frame is accepted only if that bit is 1 and `cfg_mcast_en` is high.
- R10: The address 01-80-C2-00-00-01 is accepted regardless of `cfg_mcast_en` and the hash table, and it sets `dec_mcast`.
- R11: An `rx_sof` with a valid byte while a frame is open restarts address capture, and the earlier partial bytes do not affect the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_sof | input | 1 | Marks the first byte of a frame (qualified by rx_vld) |
| rx_vld | input | 1 | rx_data carries a byte this cycle |
| rx_data | input | 8 | Received byte |
| rx_eof | input | 1 | Frame ends this cycle |
| sta_addr | input | 48 | Station address, byte 0 in bits 47:40 |
| cfg_promisc | input | 1 | Accept all addresses |
| cfg_bcast_en | input | 1 | Accept the broadcast address |
| cfg_mcast_en | input | 1 | Accept hashed multicast addresses |
| hash_tbl | input | 64 | Multicast hash table, eight 8-bit slices |
| dec_vld | output | 1 | One-cycle verdict strobe |
| dec_accept | output | 1 | Frame accepted (valid with dec_vld) |
| dec_bcast | output | 1 | Destination is broadcast (valid with dec_vld) |
| dec_mcast | output | 1 | Destination is multicast (valid with dec_vld) |

## Verification
The bench walks a single set hash bit through all 64 positions and sends several group addresses for each. A wrong key slice, CRC bit order or slice/bit split would accept the wrong addresses. It also crosses every setting of the three enables with broadcast, pause, hashed multicast, matching and near-miss unicast addresses. A missing pause exception, a reversed station byte order or an enable that leaks into another class shows up as a wrong verdict. Idle gaps inside the address, a short frame cut off by end-of-frame, a restart in mid-address, end-of-frame on the sixth byte and trailing bytes after the verdict are all driven. A miscounting capture would emit a verdict early, late, twice or on stale bytes.

// File: rtl/rx_da_filter_pkg.sv
package rx_da_filter_pkg;

   localparam int unsigned OCTET_W = 8;
   localparam int unsigned CRC_W   = 32;

   typedef logic [OCTET_W-1:0] octet_t;
   typedef logic [CRC_W-1:0]   crc_t;

   // Advance a left-shifting CRC by one octet, least significant data bit first.
   function automatic crc_t crc_octet(input crc_t crc_in, input octet_t data, input crc_t poly);
      crc_t c;
      logic fb;
      c = crc_in;
      for (int i = 0; i < OCTET_W; i++) begin
         fb = c[CRC_W-1] ^ data[i];
         c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
      end
      return c;
   endfunction

endpackage

// File: rtl/rxdaf_capture.sv
module rxdaf_capture
   import rx_da_filter_pkg::*;
#(
   parameter int unsigned ADDR_BYTES = 6
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          sof,
   input  logic                          vld,
   input  octet_t                        data,
   input  logic                          eof,
   output logic                          take,
   output logic                          start,
   output logic                          last,
   output logic [ADDR_BYTES*OCTET_W-1:0] addr_flat
);

   localparam int unsigned CNT_W  = $clog2(ADDR_BYTES + 1);
   localparam int unsigned ADDR_W = ADDR_BYTES * OCTET_W;
   localparam int unsigned HELD   = ADDR_BYTES - 1;

   logic             open_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] pos;
   logic             abort;
   logic             store;

   assign start = vld & sof;
   assign take  = vld & (sof | open_q);
   assign pos   = start ? '0 : cnt_q;
   assign last  = take & (pos == CNT_W'(ADDR_BYTES - 1));
   assign abort = eof & ~last;
   assign store = take & ~last & ~abort;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         cnt_q  <= '0;
      end else if (abort || last) begin
         open_q <= 1'b0;
         cnt_q  <= '0;
      end else if (take) begin
         open_q <= 1'b1;
         cnt_q  <= pos + CNT_W'(1);
      end
   end

   // One holding register per early address byte; the final byte is used live.
   for (genvar g = 0; g < HELD; g++) begin : g_hold
      octet_t byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            byte_q <= '0;
         end else if (store && (pos == CNT_W'(g))) begin
            byte_q <= data;
         end
      end
      assign addr_flat[ADDR_W-1-g*OCTET_W -: OCTET_W] = byte_q;
   end

   assign addr_flat[OCTET_W-1:0] = data;

endmodule

// File: rtl/rxdaf_crc.sv
module rxdaf_crc
   import rx_da_filter_pkg::*;
#(
   parameter logic [31:0] CRC_POLY = 32'h04C1_1DB7,
   parameter logic [31:0] CRC_INIT = 32'hFFFF_FFFF,
   parameter int unsigned KEY_LSB  = 25,
   parameter int unsigned KEY_W    = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             take,
   input  octet_t           data,
   output logic [KEY_W-1:0] key
);

   crc_t crc_q;
   crc_t base;
   crc_t crc_next;

   assign base     = start ? crc_t'(CRC_INIT) : crc_q;
   assign crc_next = crc_octet(base, data, crc_t'(CRC_POLY));
   assign key      = crc_next[KEY_LSB +: KEY_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q <= crc_t'(CRC_INIT);
      end else if (take) begin
         crc_q <= crc_next;
      end
   end

endmodule

// File: rtl/rxdaf_decide.sv
module rxdaf_decide
   import rx_da_filter_pkg::*;
#(
   parameter int unsigned ADDR_BYTES = 6,
   parameter int unsigned TBL_SEL_W  = 3,
   parameter int unsigned BIT_SEL_W  = 3,
   parameter logic [ADDR_BYTES*8-1:0] PAUSE_DA = 48'h0180_C200_0001
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic                                    last,
   input  logic [ADDR_BYTES*OCTET_W-1:0]           addr,
   input  logic [TBL_SEL_W+BIT_SEL_W-1:0]          key,
   input  logic [ADDR_BYTES*OCTET_W-1:0]           station,
   input  logic                                    promisc,
   input  logic                                    bcast_en,
   input  logic                                    mcast_en,
   input  logic [2**(TBL_SEL_W+BIT_SEL_W)-1:0]     hash_tbl,
   output logic                                    vld_q,
   output logic                                    accept_q,
   output logic                                    bcast_q,
   output logic                                    mcast_q
);

   localparam int unsigned ADDR_W  = ADDR_BYTES * OCTET_W;
   localparam int unsigned KEY_W   = TBL_SEL_W + BIT_SEL_W;
   localparam int unsigned N_TBL   = 2 ** TBL_SEL_W;
   localparam int unsigned TBL_W   = 2 ** BIT_SEL_W;
   localparam int unsigned GRP_BIT = ADDR_W - OCTET_W;

   logic [TBL_W-1:0]     slice [N_TBL];
   logic [TBL_SEL_W-1:0] tbl_sel;
   logic [BIT_SEL_W-1:0] bit_sel;
   logic is_grp, is_bc, is_mc, is_pause, is_own, hash_hit, accept_c;

   for (genvar t = 0; t < N_TBL; t++) begin : g_slice
      assign slice[t] = hash_tbl[t*TBL_W +: TBL_W];
   end

   assign tbl_sel  = key[KEY_W-1 -: TBL_SEL_W];
   assign bit_sel  = key[BIT_SEL_W-1:0];
   assign hash_hit = slice[tbl_sel][bit_sel];

   assign is_grp   = addr[GRP_BIT];
   assign is_bc    = &addr;
   assign is_mc    = is_grp & ~is_bc;
   assign is_pause = (addr == PAUSE_DA);
   assign is_own   = (addr == station);

   assign accept_c = promisc
                   | (is_bc & bcast_en)
                   | is_pause
                   | (is_mc & mcast_en & hash_hit)
                   | (~is_grp & is_own);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q    <= 1'b0;
         accept_q <= 1'b0;
         bcast_q  <= 1'b0;
         mcast_q  <= 1'b0;
      end else begin
         vld_q    <= last;
         accept_q <= last & accept_c;
         bcast_q  <= last & is_bc;
         mcast_q  <= last & is_mc;
      end
   end

endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter
   import rx_da_filter_pkg::*;
#(
   parameter int unsigned ADDR_BYTES = 6,
   parameter int unsigned TBL_SEL_W  = 3,
   parameter int unsigned BIT_SEL_W  = 3,
   parameter int unsigned KEY_LSB    = 25,
   parameter logic [31:0] CRC_POLY   = 32'h04C1_1DB7,
   parameter logic [31:0] CRC_INIT   = 32'hFFFF_FFFF,
   parameter logic [ADDR_BYTES*8-1:0] PAUSE_DA = 48'h0180_C200_0001
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   rx_sof,
   input  logic                                   rx_vld,
   input  logic [7:0]                             rx_data,
   input  logic                                   rx_eof,
   input  logic [ADDR_BYTES*8-1:0]                sta_addr,
   input  logic                                   cfg_promisc,
   input  logic                                   cfg_bcast_en,
   input  logic                                   cfg_mcast_en,
   input  logic [2**(TBL_SEL_W+BIT_SEL_W)-1:0]    hash_tbl,
   output logic                                   dec_vld,
   output logic                                   dec_accept,
   output logic                                   dec_bcast,
   output logic                                   dec_mcast
);

   localparam int unsigned ADDR_W = ADDR_BYTES * OCTET_W;
   localparam int unsigned KEY_W  = TBL_SEL_W + BIT_SEL_W;

   if (ADDR_BYTES < 2) begin : g_chk_len
      $error("rx_da_filter: ADDR_BYTES must be at least 2");
   end
   if (KEY_LSB + KEY_W > CRC_W) begin : g_chk_key
      $error("rx_da_filter: hash key does not fit in the CRC register");
   end
   if (TBL_SEL_W < 1 || BIT_SEL_W < 1) begin : g_chk_split
      $error("rx_da_filter: table and bit selectors need at least one bit each");
   end

   logic              take, start, last;
   logic [ADDR_W-1:0] addr_flat;
   logic [KEY_W-1:0]  key;

   rxdaf_capture #(
      .ADDR_BYTES (ADDR_BYTES)
   ) u_capture (
      .clk       (clk),
      .rst_n     (rst_n),
      .sof       (rx_sof),
      .vld       (rx_vld),
      .data      (rx_data),
      .eof       (rx_eof),
      .take      (take),
      .start     (start),
      .last      (last),
      .addr_flat (addr_flat)
   );

   rxdaf_crc #(
      .CRC_POLY (CRC_POLY),
      .CRC_INIT (CRC_INIT),
      .KEY_LSB  (KEY_LSB),
      .KEY_W    (KEY_W)
   ) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .take  (take),
      .data  (rx_data),
      .key   (key)
   );

   rxdaf_decide #(
      .ADDR_BYTES (ADDR_BYTES),
      .TBL_SEL_W  (TBL_SEL_W),
      .BIT_SEL_W  (BIT_SEL_W),
      .PAUSE_DA   (PAUSE_DA)
   ) u_decide (
      .clk      (clk),
      .rst_n    (rst_n),
      .last     (last),
      .addr     (addr_flat),
      .key      (key),
      .station  (sta_addr),
      .promisc  (cfg_promisc),
      .bcast_en (cfg_bcast_en),
      .mcast_en (cfg_mcast_en),
      .hash_tbl (hash_tbl),
      .vld_q    (dec_vld),
      .accept_q (dec_accept),
      .bcast_q  (dec_bcast),
      .mcast_q  (dec_mcast)
   );

endmodule

// File: rtl/rxdaf_check.sv
module rxdaf_check (
   input logic clk,
   input logic rst_n,
   input logic rx_vld,
   input logic cfg_promisc,
   input logic cfg_bcast_en,
   input logic dec_vld,
   input logic dec_accept,
   input logic dec_bcast,
   input logic dec_mcast
);

   p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dec_vld |=> !dec_vld);

   p_follows_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dec_vld |-> $past(rx_vld));

   p_quiet_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_vld |-> !(dec_accept || dec_bcast || dec_mcast));

   p_promisc_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_vld && $past(cfg_promisc)) |-> dec_accept);

   p_bcast_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_vld && dec_bcast && !$past(cfg_promisc)) |-> (dec_accept == $past(cfg_bcast_en)));

   p_class_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(dec_bcast && dec_mcast));

endmodule

bind rx_da_filter rxdaf_check u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .rx_vld       (rx_vld),
   .cfg_promisc  (cfg_promisc),
   .cfg_bcast_en (cfg_bcast_en),
   .dec_vld      (dec_vld),
   .dec_accept   (dec_accept),
   .dec_bcast    (dec_bcast),
   .dec_mcast    (dec_mcast)
);

// File: tb/rx_da_filter_test.sv
module rx_da_filter_test;

   localparam int CLK_PERIOD = 10;
   localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
   localparam logic [47:0] PAUSE = 48'h0180_C200_0001;
   localparam logic [47:0] STA   = 48'h0211_2233_4455;
   localparam logic [31:0] POLY  = 32'h04C1_1DB7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_sof = 1'b0, rx_vld = 1'b0, rx_eof = 1'b0;
   logic [7:0]  rx_data = 8'h00;
   logic [47:0] sta_addr = STA;
   logic        cfg_promisc = 1'b0, cfg_bcast_en = 1'b0, cfg_mcast_en = 1'b0;
   logic [63:0] hash_tbl = '0;
   logic        dec_vld, dec_accept, dec_bcast, dec_mcast;

   int n_chk = 0;
   int n_err = 0;
   int cyc   = 0;

   rx_da_filter uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .rx_sof       (rx_sof),
      .rx_vld       (rx_vld),
      .rx_data      (rx_data),
      .rx_eof       (rx_eof),
      .sta_addr     (sta_addr),
      .cfg_promisc  (cfg_promisc),
      .cfg_bcast_en (cfg_bcast_en),
      .cfg_mcast_en (cfg_mcast_en),
      .hash_tbl     (hash_tbl),
      .dec_vld      (dec_vld),
      .dec_accept   (dec_accept),
      .dec_bcast    (dec_bcast),
      .dec_mcast    (dec_mcast)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=%0d cycles expected=finish", cyc);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mdl_crc(input logic [47:0] da);
      logic [31:0] r;
      logic [7:0]  b;
      logic        fb;
      r = 32'hFFFF_FFFF;
      for (int i = 0; i < 6; i++) begin
         b = da[47-8*i -: 8];
         for (int j = 0; j < 8; j++) begin
            fb = r[31] ^ b[j];
            r  = {r[30:0], 1'b0} ^ (fb ? POLY : 32'h0);
         end
      end
      return r;
   endfunction

   task automatic mdl(input logic [47:0] da, output logic acc, output logic bc, output logic mc);
      logic [31:0] c;
      logic [5:0]  key;
      logic        grp, pse;
      c   = mdl_crc(da);
      key = c[30:25];
      bc  = (da == BCAST);
      grp = da[40];
      mc  = grp & !bc;
      pse = (da == PAUSE);
      acc = cfg_promisc | (bc & cfg_bcast_en) | pse
          | (mc & cfg_mcast_en & hash_tbl[key]) | (!grp & (da == sta_addr));
   endtask

   task automatic send_frame(input logic [47:0] da, input int gap_at, input string req);
      logic acc, bc, mc;
      for (int i = 0; i < 6; i++) begin
         if (i == gap_at) begin
            @(negedge clk);
            rx_vld = 1'b0;
            rx_sof = 1'b0;
         end
         @(negedge clk);
         if (i > 0) chk("R2", "no verdict inside address", 64'(dec_vld), 64'(0));
         rx_vld  = 1'b1;
         rx_sof  = (i == 0);
         rx_data = da[47-8*i -: 8];
      end
      @(negedge clk);
      rx_vld = 1'b0;
      rx_sof = 1'b0;
      mdl(da, acc, bc, mc);
      chk("R2", "verdict strobe", 64'(dec_vld), 64'(1));
      chk(req, "accept", 64'(dec_accept), 64'(acc));
      chk("R6", "broadcast flag", 64'(dec_bcast), 64'(bc));
      chk("R8", "multicast flag", 64'(dec_mcast), 64'(mc));
      @(negedge clk);
      chk("R2", "single pulse", 64'(dec_vld), 64'(0));
      chk("R3", "flags quiet", 64'({dec_accept, dec_bcast, dec_mcast}), 64'(0));
   endtask

   task automatic stray_bytes(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk(req, "no verdict from stray bytes", 64'(dec_vld), 64'(0));
         rx_vld  = 1'b1;
         rx_sof  = 1'b0;
         rx_data = STA[47-8*(i%6) -: 8];
      end
      @(negedge clk);
      rx_vld = 1'b0;
      chk(req, "no verdict from stray bytes", 64'(dec_vld), 64'(0));
      @(negedge clk);
      chk(req, "no verdict from stray bytes", 64'(dec_vld), 64'(0));
   endtask

   initial begin
      logic [47:0] list [6];
      list[0] = BCAST;
      list[1] = PAUSE;
      list[2] = 48'h0100_5E01_0203;
      list[3] = STA;
      list[4] = STA ^ 48'h0000_0000_0001;
      list[5] = {STA[15:0], STA[31:16], STA[47:32]};

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1", "strobe in reset", 64'(dec_vld), 64'(0));
      chk("R1", "flags in reset", 64'({dec_accept, dec_bcast, dec_mcast}), 64'(0));
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1", "strobe after reset", 64'(dec_vld), 64'(0));

      // R5 R6 R7 R10: every enable combination against every address class
      for (int h = 0; h < 2; h++) begin
         hash_tbl = (h == 0) ? 64'h0 : '1;
         for (int c = 0; c < 8; c++) begin
            cfg_promisc  = c[0];
            cfg_bcast_en = c[1];
            cfg_mcast_en = c[2];
            for (int a = 0; a < 6; a++) begin
               case (a)
                  0: send_frame(list[a], -1, "R6");
                  1: send_frame(list[a], 2, "R10");
                  2: send_frame(list[a], -1, "R9");
                  default: send_frame(list[a], (a + c) % 7, c[0] ? "R5" : "R7");
               endcase
            end
         end
      end

      // R9: walk one set hash bit over all 64 positions
      cfg_promisc  = 1'b0;
      cfg_bcast_en = 1'b0;
      cfg_mcast_en = 1'b1;
      for (int k = 0; k < 64; k++) begin
         hash_tbl = 64'h1 << k;
         for (int n = 0; n < 4; n++) begin
            send_frame({8'h01, 8'h00, 8'h5E, 8'(k), 8'(n * 37), 8'(k ^ n)}, k % 7, "R9");
         end
      end
      // R9: multicast enable low blocks a hashed hit
      hash_tbl     = '1;
      cfg_mcast_en = 1'b0;
      send_frame(48'h3300_0000_0001, -1, "R9");
      send_frame(PAUSE, -1, "R10");

      // R3: bytes after the verdict and before the next start
      cfg_mcast_en = 1'b1;
      send_frame(STA, -1, "R7");
      stray_bytes(8, "R3");

      // R4: end-of-frame after three bytes drops the frame
      @(negedge clk);
      rx_vld = 1'b1; rx_sof = 1'b1; rx_data = STA[47:40];
      @(negedge clk);
      rx_sof = 1'b0; rx_data = STA[39:32];
      @(negedge clk);
      rx_data = STA[31:24];
      @(negedge clk);
      rx_vld = 1'b0; rx_eof = 1'b1;
      @(negedge clk);
      rx_eof = 1'b0;
      chk("R4", "no verdict after short frame", 64'(dec_vld), 64'(0));
      stray_bytes(6, "R4");
      send_frame(STA, -1, "R4");

      // R4: end-of-frame together with the sixth byte still gives a verdict
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         rx_vld  = 1'b1;
         rx_sof  = (i == 0);
         rx_eof  = (i == 5);
         rx_data = STA[47-8*i -: 8];
      end
      @(negedge clk);
      rx_vld = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
      chk("R4", "verdict with eof on last byte", 64'(dec_vld), 64'(1));
      chk("R4", "accept with eof on last byte", 64'(dec_accept), 64'(1));

      // R11: restart in mid-address
      cfg_bcast_en = 1'b0;
      @(negedge clk);
      rx_vld = 1'b1; rx_sof = 1'b1; rx_data = 8'hFF;
      @(negedge clk);
      rx_sof = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rx_vld = 1'b0;
      send_frame(STA, -1, "R11");
      send_frame(list[5], -1, "R11");

      repeat (3) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule